// File: doc/BRIEF.md
# Seconds Real-Time Clock with Two Alarms and Rate Trim

The block keeps wall time as a 32-bit count of seconds. Each second is built from a slow tick enable, nominally 32768 ticks. Software can load the counter directly and read it back over a small word-addressed register bus. The bus has an address, a write strobe, write data, and read data that is returned in the same cycle.

There are two alarm slots. Each slot has a compare value, a three-bit interrupt configuration and a sticky status flag. When the counter steps onto a slot's compare value, the flag sets, and the slot's interrupt line follows the flag when the alarm enable is on. The same line can also carry a one-cycle pulse on every second boundary.

A signed 8-bit trim value corrects oscillator drift. Once per correction window, it shortens or lengthens one second by a whole number of ticks. The step size is selected as fine or coarse (four times fine). The trim only takes effect when the bits above it carry a guard pattern derived from its sign bit.

Top module: `rtc_dual_alarm`

## Requirements
- R1: After reset the time, compare values, configurations, trim register and status all read 0, and both interrupt lines are low.
- R2: Registers sit at word offsets: status 0x00, slot-0 config 0x04, slot-1 config 0x08, time 0x0C, slot-0 compare 0x10, slot-1 compare 0x14, trim 0x18. Configs keep write bits 2..0. Trim keeps bits 15..0. Any other offset reads 0, and writes to it change nothing.
- R3: With the trim inactive, the time increments by one after exactly TICKS_PER_SEC tick enables. It does not move while the tick is low. Writing the time register loads the value and restarts the current second from zero ticks.
- R4: A status flag (bit 0 for slot 0, bit 1 for slot 1) sets on the tick edge where the time steps to a value equal to that slot's compare. Loading the time to the compare value through the bus does not set it.
- R5: Writing 1 to a status bit clears it, and writing 0 leaves it. When a set and a clear land in the same cycle, the flag ends up set.
- R6: Interrupt line k is high while status flag k and config bit 0 of slot k are both 1. Writing 0 to the config drops the line while the flag stays.
- R7: When config bits 1 and 2 are both set, line k pulses high for exactly one cycle, in the cycle after each second boundary. Bit 1 alone produces no pulse.
- R8: Trim bits 7..0 hold a signed value v, and bit 15 selects coarse. The first second of every WINDOW_SECS-second window lasts TICKS_PER_SEC − v·step ticks, where step is FINE_STEP, or 4·FINE_STEP in coarse mode. A positive v shortens that second. The defaults give 32 ticks per fine step, about 954 ppb.
- R9: Trim bits 14..8 must equal {0, ~S, S, S, S, S, S}, with S being bit 7. Any other pattern is stored but leaves every second at TICKS_PER_SEC ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Slow tick enable, one clock wide per tick |
| addr_i | input | 5 | Register byte offset |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, same cycle |
| irq_o | output | 2 | Interrupt line per alarm slot |

## Verification
The hardest case to reach is a software clear of a status flag that arrives on the same edge as the hardware set. The stimulus gets there by loading the time one below the compare value, which also restarts the second at a known tick phase. It then counts TICKS_PER_SEC−1 ticks and drives the final tick together with the clear write. The trim is measured across a full window, starting from an observed second boundary. This way the single corrected second is always counted once, whatever the window phase was when the trim was written.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W     = 5;
  localparam int NUM_ALARMS = 2;

  localparam logic [ADDR_W-1:0] OFS_STATUS = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_CFG0   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_TIME   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CMP0   = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_TRIM   = 5'h18;

  typedef struct packed {
    logic hz1;
    logic per_en;
    logic alm_en;
  } alm_cfg_t;
endpackage

// File: rtl/rtc_rate_gen.sv
module rtc_rate_gen #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int WINDOW_SECS   = 1024,
  parameter int FINE_STEP     = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        restart_i,
  input  logic [15:0] trim_i,
  output logic        sec_stb_o
);
  localparam int COARSE_STEP = 4 * FINE_STEP;
  localparam int MAX_ADJ     = 128 * COARSE_STEP;
  localparam int LEN_W       = $clog2(TICKS_PER_SEC + MAX_ADJ + 1);
  localparam int WIN_W       = $clog2(WINDOW_SECS);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW_SECS - 1);

  logic [LEN_W-1:0] sub_q, len, last;
  logic [WIN_W-1:0] win_q;
  logic             sgn, pat_ok, roll;
  int               adj, len_int;

  assign sgn    = trim_i[7];
  assign pat_ok = (trim_i[14:8] == {1'b0, ~sgn, {5{sgn}}});

  always_comb begin
    adj = 0;
    if (pat_ok && win_q == '0)
      adj = int'($signed(trim_i[7:0])) * (trim_i[15] ? COARSE_STEP : FINE_STEP);
    len_int = TICKS_PER_SEC - adj;
  end

  assign len       = len_int[LEN_W-1:0];
  assign last      = len - 1'b1;
  assign roll      = tick_i && !restart_i && (sub_q >= last);
  assign sec_stb_o = roll;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q <= '0;
      win_q <= '0;
    end else if (restart_i) begin
      sub_q <= '0;
    end else if (tick_i) begin
      if (roll) begin
        sub_q <= '0;
        win_q <= (win_q == WIN_LAST) ? '0 : win_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  // seconds are always at least two ticks long
  a_r8_stb_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_stb_o |=> !sec_stb_o);
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sec_stb_i,
  input  logic [31:0] sec_next_i,
  input  logic [31:0] cmp_i,
  input  logic        clr_i,
  input  alm_cfg_t    cfg_i,
  input  logic        pulse_i,
  output logic        status_o,
  output logic        irq_o
);
  logic hit, status_q;

  assign hit = sec_stb_i && (sec_next_i == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= 1'b0;
    else         status_q <= hit | (status_q & ~clr_i);
  end

  assign status_o = status_q;
  assign irq_o    = (status_q & cfg_i.alm_en) | (pulse_i & cfg_i.per_en & cfg_i.hz1);

  a_r4_set_only_on_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o) |-> $past(sec_stb_i));
  a_r5_set_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && clr_i) |=> status_o);
  a_r5_drop_needs_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o) |-> $past(clr_i));
  a_r6_irq_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !pulse_i) |-> status_o);
endmodule

// File: rtl/rtc_dual_alarm.sv
module rtc_dual_alarm
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int WINDOW_SECS   = 1024,
  parameter int FINE_STEP     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [NUM_ALARMS-1:0] irq_o
);
  logic [31:0]           sec_q, sec_next;
  logic [15:0]           trim_q;
  logic [31:0]           cmp_q [NUM_ALARMS];
  alm_cfg_t              cfg_q [NUM_ALARMS];
  logic [NUM_ALARMS-1:0] status, clr;
  logic                  sec_stb, time_ld, pulse_q;

  assign time_ld  = we_i && addr_i == OFS_TIME;
  assign sec_next = sec_q + 1'b1;
  assign clr      = (we_i && addr_i == OFS_STATUS) ? wdata_i[NUM_ALARMS-1:0] : '0;

  rtc_rate_gen #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .WINDOW_SECS  (WINDOW_SECS),
    .FINE_STEP    (FINE_STEP)
  ) u_rate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .restart_i(time_ld),
    .trim_i   (trim_q),
    .sec_stb_o(sec_stb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q   <= '0;
      trim_q  <= '0;
      pulse_q <= 1'b0;
      for (int k = 0; k < NUM_ALARMS; k++) begin
        cmp_q[k] <= '0;
        cfg_q[k] <= '0;
      end
    end else begin
      pulse_q <= sec_stb;
      if (time_ld)      sec_q <= wdata_i;
      else if (sec_stb) sec_q <= sec_next;
      if (we_i && addr_i == OFS_TRIM) trim_q <= wdata_i[15:0];
      for (int k = 0; k < NUM_ALARMS; k++) begin
        if (we_i && addr_i == OFS_CFG0 + ADDR_W'(4 * k)) cfg_q[k] <= alm_cfg_t'(wdata_i[2:0]);
        if (we_i && addr_i == OFS_CMP0 + ADDR_W'(4 * k)) cmp_q[k] <= wdata_i;
      end
    end
  end

  for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_alarm
    rtc_alarm_unit u_alarm (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sec_stb_i (sec_stb),
      .sec_next_i(sec_next),
      .cmp_i     (cmp_q[g]),
      .clr_i     (clr[g]),
      .cfg_i     (cfg_q[g]),
      .pulse_i   (pulse_q),
      .status_o  (status[g]),
      .irq_o     (irq_o[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFS_STATUS) rdata_o = {{(32-NUM_ALARMS){1'b0}}, status};
    if (addr_i == OFS_TIME)   rdata_o = sec_q;
    if (addr_i == OFS_TRIM)   rdata_o = {16'h0, trim_q};
    for (int k = 0; k < NUM_ALARMS; k++) begin
      if (addr_i == OFS_CFG0 + ADDR_W'(4 * k)) rdata_o = {29'h0, cfg_q[k]};
      if (addr_i == OFS_CMP0 + ADDR_W'(4 * k)) rdata_o = cmp_q[k];
    end
  end

  a_r3_time_moves_on_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sec_q) |-> $past(sec_stb || time_ld));
  a_r7_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);
endmodule

// File: tb/rtc_dual_alarm_bench.sv
module rtc_dual_alarm_bench;
  localparam int TPS = 1024;
  localparam int WIN = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [1:0]  irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  rtc_dual_alarm #(.TICKS_PER_SEC(TPS), .WINDOW_SECS(WIN), .FINE_STEP(1)) u_rtc_dual_alarm (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .addr_i(addr_i),
    .we_i(we_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  // {addr, wdata, expected read-back}
  localparam logic [68:0] VEC [8] = '{
    {5'h04, 32'hFFFF_FFFF, 32'h0000_0007},
    {5'h08, 32'h0000_0005, 32'h0000_0005},
    {5'h10, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {5'h14, 32'h1234_5678, 32'h1234_5678},
    {5'h0C, 32'h0000_0064, 32'h0000_0064},
    {5'h18, 32'hFFFF_A07F, 32'h0000_A07F},
    {5'h1C, 32'hFFFF_FFFF, 32'h0000_0000},
    {5'h00, 32'h0000_0003, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic window_len(output int cyc);
    logic [31:0] t0, t1, v;
    cyc = 0;
    @(negedge clk);
    rd(5'h0C, t0);
    tick_i = 1'b1;
    do begin @(negedge clk); rd(5'h0C, t1); end while (t1 == t0);
    do begin @(negedge clk); cyc++; rd(5'h0C, v); end while (v != t1 + 4);
    tick_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int          len;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5'h0C, v); check("R1 time", v, 0);
    rd(5'h00, v); check("R1 status", v, 0);
    rd(5'h18, v); check("R1 trim", v, 0);
    rd(5'h10, v); check("R1 cmp0", v, 0);
    check("R1 irq", {30'h0, irq_o}, 0);

    // R2 register map walk
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][68:64], VEC[i][63:32]);
      rd(VEC[i][68:64], v);
      check("R2 map", v, VEC[i][31:0]);
    end
    rd(5'h0C, v); check("R2 unmapped write ignored", v, 32'h64);
    wr(5'h04, 0); wr(5'h08, 0); wr(5'h18, 0);
    wr(5'h10, 32'hFFFF_FFF0); wr(5'h14, 32'hFFFF_FFF0);

    // R3 counting and load
    wr(5'h0C, 32'd100);
    repeat (10) @(negedge clk);
    rd(5'h0C, v); check("R3 no tick no advance", v, 100);
    ticks(TPS - 1); rd(5'h0C, v); check("R3 one tick short", v, 100);
    ticks(1);       rd(5'h0C, v); check("R3 full second", v, 101);
    ticks(TPS / 2);
    wr(5'h0C, 32'd200);
    ticks(TPS - 1); rd(5'h0C, v); check("R3 load restarts second", v, 200);
    ticks(1);       rd(5'h0C, v); check("R3 after restart", v, 201);

    // R4 / R6 alarm slot 0
    wr(5'h0C, 32'd9); wr(5'h10, 32'd10); wr(5'h04, 32'd1);
    ticks(TPS - 1);
    rd(5'h00, v); check("R4 not yet", v, 0);
    ticks(1);
    rd(5'h00, v); check("R4 slot0 set", v, 1);
    check("R6 irq0 high", {30'h0, irq_o}, 1);
    wr(5'h04, 0);
    check("R6 cfg zero drops irq", {30'h0, irq_o}, 0);
    rd(5'h00, v); check("R6 status kept", v, 1);
    wr(5'h04, 32'd1);

    // R5 write-one-to-clear
    wr(5'h00, 0);  rd(5'h00, v); check("R5 write zero", v, 1);
    wr(5'h00, 2);  rd(5'h00, v); check("R5 other bit", v, 1);
    wr(5'h00, 1);  rd(5'h00, v); check("R5 clear", v, 0);
    check("R5 irq after clear", {30'h0, irq_o}, 0);

    // R4 load onto compare value does not set
    wr(5'h14, 32'd50); wr(5'h08, 32'd1); wr(5'h0C, 32'd50);
    repeat (3) @(negedge clk);
    rd(5'h00, v); check("R4 load no set", v, 0);
    ticks(TPS - 1);
    wr(5'h0C, 32'd49);
    ticks(TPS);
    rd(5'h00, v); check("R4 slot1 set", v, 2);
    check("R6 irq1 high", {30'h0, irq_o}, 2);
    wr(5'h00, 2); wr(5'h08, 0); wr(5'h14, 32'hFFFF_FFF0);

    // R5 set beats clear in same cycle
    wr(5'h0C, 32'd19); wr(5'h10, 32'd20);
    ticks(TPS - 1);
    @(negedge clk);
    tick_i = 1'b1; we_i = 1'b1; addr_i = 5'h00; wdata_i = 32'd1;
    @(negedge clk);
    tick_i = 1'b0; we_i = 1'b0;
    rd(5'h0C, v); check("R5 time at collision", v, 20);
    rd(5'h00, v); check("R5 set wins", v, 1);
    wr(5'h00, 1); wr(5'h04, 0);

    // R7 periodic pulse
    wr(5'h08, 32'd6); wr(5'h0C, 32'd300);
    ticks(TPS);
    check("R7 pulse high", {30'h0, irq_o}, 2);
    @(negedge clk);
    check("R7 pulse one cycle", {30'h0, irq_o}, 0);
    wr(5'h08, 32'd2); wr(5'h0C, 32'd300);
    ticks(TPS);
    check("R7 bit1 alone no pulse", {30'h0, irq_o}, 0);
    wr(5'h08, 0);

    // R8 / R9 trim over one window
    wr(5'h18, 0);      window_len(len); check("R8 no trim", len, WIN * TPS);
    wr(5'h18, 32'h2003); window_len(len); check("R8 fine +3", len, WIN * TPS - 3);
    wr(5'h18, 32'h9FFE); window_len(len); check("R8 coarse -2", len, WIN * TPS + 8);
    wr(5'h18, 32'hA07F); window_len(len); check("R8 coarse +127", len, WIN * TPS - 508);
    wr(5'h18, 32'h9F80); window_len(len); check("R8 coarse -128", len, WIN * TPS + 512);
    wr(5'h18, 32'h6003); window_len(len); check("R9 bad pattern", len, WIN * TPS);

    finish_run();
  end
endmodule